// File: doc/BRIEF.md
# Two-Level Lookahead Adder

This block is a purely combinational 16-bit binary adder with a carry input and a carry output. It is organised as four 4-bit slices. Every slice forms a generate (both operand bits set) and a propagate (either operand bit set) for each bit position. From these and its own carry input, each slice produces every internal carry in flattened sum-of-products form, so nothing ripples from one bit to the next. Each slice also reports whether it creates a carry by itself (slice generate) and whether it would pass an incoming carry through (slice propagate).

A second lookahead stage applies the same flattened equations to the four slice generate/propagate pairs and the external carry input. From this it derives the carry into each slice and the final carry output. Both levels use one parameterised lookahead module. The adder fits wherever a wide sum is needed within a single cycle, and it adds no registers to the path.

Top module: `lookaheadAdder`

## Requirements
- R1: For any operands and carry input, the concatenation {carryOut, sumOut} equals opA + opB + carryIn, computed as a 17-bit unsigned sum.
- R2: With carryIn = 1, the result is exactly one greater than with carryIn = 0 for the same operands.
- R3: opA = 16'hFFFF, opB = 16'h0000, carryIn = 1 gives sumOut = 16'h0000 and carryOut = 1. The carry input passes through all sixteen propagating bits.
- R4: When both operands have bit 15 set, carryOut is 1 whatever the lower bits are, for example 16'h8000 + 16'h8000 = 16'h0000 with carryOut = 1.
- R5: A carry produced in a lower 4-bit slice reaches the next slice correctly at every slice boundary (bits 3→4, 7→8 and 11→12), for example 16'h000F + 16'h0001 = 16'h0010 and 16'h0FFF + 16'h0001 = 16'h1000.
- R6: When no bit position has both operand bits set and carryIn = 0, sumOut equals opA OR opB and carryOut is 0.
- R7: The outputs depend only on the present inputs. A new input value is reflected at the outputs without any clock edge.
- R8: Within each lookahead stage, every carry equals the generate of the position below it, OR that position's propagate ANDed with the carry below it. A slice or top-level carry output is 1 whenever the stage generate is 1, or the stage propagate and its carry input are both 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 16 | First addend |
| opB | input | 16 | Second addend |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | 16 | Sum bits |
| carryOut | output | 1 | Carry out of bit 15 |

## Verification
All-zero operands establish the idle result. A lone carry input tells an added carry apart from a dropped one. All ones plus a carry input shows whether propagate chains through both lookahead levels, while paired top bits show whether a generate reaches the output independently of the lower bits. Operand pairs that fill a slice and add one show whether the second-level carries land in the correct slice. Disjoint bit patterns rule out any false generate. Fixed-seed random pairs cover the mixed cases against a plain integer addition.

// File: rtl/claPkg.sv
package claPkg;
  // width of one lookahead slice
  parameter int GROUP_W    = 4;
  // number of slices combined by the second level
  parameter int NUM_GROUPS = 4;
  // derived total operand width
  localparam int TOTAL_W   = GROUP_W * NUM_GROUPS;

  // generate/propagate pair reported by a slice
  typedef struct packed {
    logic gen;
    logic prop;
  } gpPair_t;
endpackage

// File: rtl/claLookahead.sv
// Flattened lookahead: each carry is an OR of product terms built only from
// the gen/prop inputs and the carry input, never from a lower carry.
module claLookahead #(
  parameter int N = 4
) (
  input  logic [N-1:0] genIn,
  input  logic [N-1:0] propIn,
  input  logic         carryIn,
  output logic [N:0]   carryVec,
  output logic         blockGen,
  output logic         blockProp
);

  always_comb begin
    logic acc;
    logic term;
    carryVec[0] = carryIn;
    for (int k = 0; k < N; k++) begin
      acc = 1'b0;
      for (int j = 0; j <= k; j++) begin
        term = genIn[j];
        for (int m = j + 1; m <= k; m++) term = term & propIn[m];
        acc = acc | term;
      end
      term = carryIn;
      for (int m = 0; m <= k; m++) term = term & propIn[m];
      carryVec[k+1] = acc | term;
    end
  end

  always_comb begin
    logic acc;
    logic term;
    acc = 1'b0;
    for (int j = 0; j < N; j++) begin
      term = genIn[j];
      for (int m = j + 1; m < N; m++) term = term & propIn[m];
      acc = acc | term;
    end
    blockGen = acc;
  end

  assign blockProp = &propIn;

  // Cross-check the flattened carries against the serial recurrence.
  always_comb begin
    if (!$isunknown({genIn, propIn, carryIn})) begin
      for (int k = 0; k < N; k++) begin
        // R8
        carry_recur_chk: assert (carryVec[k+1] == (genIn[k] | (propIn[k] & carryVec[k])))
          else $error("carry %0d breaks recurrence", k + 1);
      end
      // R8
      block_out_chk: assert (carryVec[N] == (blockGen | (blockProp & carryIn)))
        else $error("block carry disagrees with block gen/prop");
    end
  end

endmodule

// File: rtl/claGroup.sv
// One slice: bitwise gen/prop, local lookahead, sum bits.
module claGroup
  import claPkg::*;
#(
  parameter int W = GROUP_W
) (
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  input  logic         cIn,
  output logic [W-1:0] sumBits,
  output gpPair_t      grpGp
);

  logic [W-1:0] bitGen;
  logic [W-1:0] bitProp;
  logic [W:0]   localCarry;
  logic         localGen;
  logic         localProp;

  assign bitGen  = aIn & bIn;
  assign bitProp = aIn | bIn;

  claLookahead #(.N(W)) i_localLa (
    .genIn    (bitGen),
    .propIn   (bitProp),
    .carryIn  (cIn),
    .carryVec (localCarry),
    .blockGen (localGen),
    .blockProp(localProp)
  );

  assign sumBits     = aIn ^ bIn ^ localCarry[W-1:0];
  assign grpGp.gen   = localGen;
  assign grpGp.prop  = localProp;

  always_comb begin
    if (!$isunknown({aIn, bIn, cIn})) begin
      // R8
      grp_gen_chk: assert (!localGen || localCarry[W])
        else $error("slice generate without carry out");
      // R8
      grp_kill_chk: assert (localGen || localProp || !localCarry[W])
        else $error("slice carry out with neither gen nor prop");
      // R1
      grp_sum_chk: assert ({localCarry[W], sumBits} == ({1'b0, aIn} + {1'b0, bIn} + {{W{1'b0}}, cIn}))
        else $error("slice sum wrong");
    end
  end

endmodule

// File: rtl/lookaheadAdder.sv
// Top: slices plus second-level lookahead over their gen/prop pairs.
module lookaheadAdder
  import claPkg::*;
#(
  parameter int GW = GROUP_W,
  parameter int NG = NUM_GROUPS,
  localparam int W = GW * NG
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         carryIn,
  output logic [W-1:0] sumOut,
  output logic         carryOut
);

  gpPair_t [NG-1:0] grpGp;
  logic [NG-1:0]    grpGen;
  logic [NG-1:0]    grpProp;
  logic [NG:0]      grpCarry;
  logic             topGen;
  logic             topProp;

  for (genvar g = 0; g < NG; g++) begin : gSlice
    claGroup #(.W(GW)) i_slice (
      .aIn    (opA[g*GW +: GW]),
      .bIn    (opB[g*GW +: GW]),
      .cIn    (grpCarry[g]),
      .sumBits(sumOut[g*GW +: GW]),
      .grpGp  (grpGp[g])
    );
    assign grpGen[g]  = grpGp[g].gen;
    assign grpProp[g] = grpGp[g].prop;
  end

  claLookahead #(.N(NG)) i_topLa (
    .genIn    (grpGen),
    .propIn   (grpProp),
    .carryIn  (carryIn),
    .carryVec (grpCarry),
    .blockGen (topGen),
    .blockProp(topProp)
  );

  assign carryOut = grpCarry[NG];

  always_comb begin
    logic [W:0] refSum;
    refSum = {1'b0, opA} + {1'b0, opB} + {{W{1'b0}}, carryIn};
    if (!$isunknown({opA, opB, carryIn})) begin
      // R1
      total_sum_chk: assert ({carryOut, sumOut} == refSum)
        else $error("total sum wrong");
      for (int g = 1; g < NG; g++) begin
        // R5
        boundary_carry_chk: assert (grpCarry[g] == (refSum[g*GW] ^ opA[g*GW] ^ opB[g*GW]))
          else $error("carry into slice %0d wrong", g);
      end
      // R3
      full_prop_chk: assert (!(topProp && carryIn) || carryOut)
        else $error("full propagate lost carry");
      // R4
      top_gen_chk: assert (!topGen || carryOut)
        else $error("top generate lost");
    end
  end

endmodule

// File: tb/test_lookaheadAdder.sv
module test_lookaheadAdder;

  logic        clk = 1'b0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic        carryIn = 1'b0;
  logic [15:0] sumOut;
  logic        carryOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  lookaheadAdder i_lookaheadAdder (
    .opA     (opA),
    .opB     (opB),
    .carryIn (carryIn),
    .sumOut  (sumOut),
    .carryOut(carryOut)
  );

  // drive at falling edge, sample 1 ns later (no clock edge between: R7)
  task automatic addCheck(input logic [15:0] a, input logic [15:0] b,
                          input logic c, input string req);
    logic [16:0] expd;
    @(negedge clk);
    opA = a; opB = b; carryIn = c;
    #1;
    expd = {1'b0, a} + {1'b0, b} + {16'b0, c};
    nChecks++;
    if ({carryOut, sumOut} !== expd) begin
      nFails++;
      $display("FAIL %s: %h+%h+%b actual %h expected %h", req, a, b, c,
               {carryOut, sumOut}, expd);
    end
  endtask

  task automatic outCheck(input logic [16:0] expd, input string req);
    nChecks++;
    if ({carryOut, sumOut} !== expd) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, {carryOut, sumOut}, expd);
    end
  endtask

  task automatic tIdle();  // R1 zero operands
    addCheck(16'h0000, 16'h0000, 1'b0, "R1");
    outCheck(17'h00000, "R1");
  endtask

  task automatic tCarryIn();  // R2
    logic [16:0] r0;
    addCheck(16'h1234, 16'h4321, 1'b0, "R2");
    r0 = {carryOut, sumOut};
    addCheck(16'h1234, 16'h4321, 1'b1, "R2");
    outCheck(r0 + 17'd1, "R2");
    addCheck(16'h0000, 16'h0000, 1'b1, "R2");
  endtask

  task automatic tFullPropagate();  // R3
    addCheck(16'hFFFF, 16'h0000, 1'b1, "R3");
    outCheck(17'h10000, "R3");
    addCheck(16'hFFFF, 16'h0001, 1'b0, "R3");
    addCheck(16'hAAAA, 16'h5555, 1'b1, "R3");
    outCheck(17'h10000, "R3");
  endtask

  task automatic tTopGenerate();  // R4
    addCheck(16'h8000, 16'h8000, 1'b0, "R4");
    outCheck(17'h10000, "R4");
    addCheck(16'h8123, 16'h8000, 1'b1, "R4");
    addCheck(16'hFFFF, 16'hFFFF, 1'b1, "R4");
  endtask

  task automatic tBoundary();  // R5
    addCheck(16'h000F, 16'h0001, 1'b0, "R5");
    outCheck(17'h00010, "R5");
    addCheck(16'h00FF, 16'h0001, 1'b0, "R5");
    outCheck(17'h00100, "R5");
    addCheck(16'h0FFF, 16'h0001, 1'b0, "R5");
    outCheck(17'h01000, "R5");
    addCheck(16'h0008, 16'h0008, 1'b0, "R5");
    addCheck(16'h0080, 16'h0080, 1'b0, "R5");
    addCheck(16'h0800, 16'h0800, 1'b0, "R5");
    addCheck(16'h0007, 16'h0008, 1'b1, "R5");
  endtask

  task automatic tNoGenerate();  // R6
    addCheck(16'hA5A5, 16'h5A5A, 1'b0, "R6");
    outCheck(17'h0FFFF, "R6");
    addCheck(16'hF000, 16'h0F0F, 1'b0, "R6");
    outCheck(17'h0FF0F, "R6");
  endtask

  task automatic tSettle();  // R7: change inputs twice within one low phase
    @(negedge clk);
    opA = 16'h0001; opB = 16'h0002; carryIn = 1'b0;
    #1 outCheck(17'h00003, "R7");
    opA = 16'h7FFF; opB = 16'h0001;
    #1 outCheck(17'h08000, "R7");
  endtask

  task automatic tRandom();  // R1, R8 across random pairs
    int unsigned seed = 32'h1F2E3D4C;
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      logic [15:0] b;
      logic        c;
      a = 16'($urandom(seed));
      seed = seed + 32'h9E3779B9;
      b = 16'($urandom(seed));
      seed = seed + 32'h7F4A7C15;
      c = 1'($urandom(seed));
      seed = seed + 32'h3C6EF372;
      addCheck(a, b, c, "R1");
    end
    for (int k = 0; k < 16; k++) begin
      addCheck(16'hFFFF >> k, 16'h0001 << k, 1'b0, "R8");
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    tIdle();
    tCarryIn();
    tFullPropagate();
    tTopGenerate();
    tBoundary();
    tNoGenerate();
    tSettle();
    tRandom();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule